// File: doc/BRIEF.md
# ECC Error Event Capture Unit

This block sits beside a memory ECC checker and keeps a record of the most recent qualifying error. The checker reports a correctable (single-bit) event or a non-correctable event as a one-cycle pulse. Each pulse comes with sideband information: the access address, the 8-bit syndrome, the 4-bit identifier of the requesting bus master, the access attributes and the data word.

When the configuration enable for the event's type is set, the block loads all five sideband values into read-only capture registers on one clock edge. It also sets a sticky flag for that type. Software uses a simple register port to program the enables, read and clear the flags (write-one-to-clear) and read the capture registers.

Syndromes above 0x4D cannot name a single flipped bit. A correctable pulse carrying such a syndrome is therefore treated as non-correctable.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset, every register offset reads zero: configuration, flags and all capture registers.
- R2: A correctable pulse with a syndrome of 0x4D or below loads address, syndrome, master id, attributes and data on the same edge, but only while the correctable enable (configuration bit 0) is set. On that edge it also sets the correctable flag (status bit 0).
- R3: A non-correctable pulse loads all capture registers on the same edge, but only while the non-correctable enable (configuration bit 1) is set. On that edge it also sets the non-correctable flag (status bit 1).
- R4: An event whose type enable is clear changes no capture register and no flag.
- R5: A correctable pulse whose syndrome exceeds 0x4D is handled as a non-correctable event: it is gated by configuration bit 1 and sets status bit 1. Syndrome 0x4D itself stays correctable.
- R6: When both pulses arrive in the same cycle, they form a single non-correctable event, and status bit 0 is not set by it.
- R7: Each new enabled event overwrites the previous capture.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a clear and a new event hit the same flag in the same cycle, the flag ends up set.
- R10: Writes to the capture offsets are ignored.
- R11: Read data appears on the cycle after the offset is presented and reflects the registers as they were before that edge. Offsets 8 to 15 read zero.
- R12: Register map (word offset on reg_addr_i):
  - 0: configuration, read/write, bits [1:0]; other bits read 0.
  - 1: status, bits [1:0].
  - 2: address.
  - 3: syndrome in bits [7:0].
  - 4: master id in bits [3:0].
  - 5: attributes in bits [7:0].
  - 6: data bits [31:0].
  - 7: data bits [63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sbc_pulse_i | input | 1 | Correctable event pulse |
| nce_pulse_i | input | 1 | Non-correctable event pulse |
| err_addr_i | input | 32 | Access address of the event |
| err_syn_i | input | 8 | Syndrome |
| err_mid_i | input | 4 | Requesting bus master id |
| err_attr_i | input | 8 | Access attributes |
| err_data_i | input | 64 | Data word of the access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
The bench targets these corner cases:
- The 0x4D/0x4E syndrome boundary. A design that compares off by one would flag the wrong type at one of those two values.
- Two pulses arriving together. A design that gets this wrong would set both flags, or only the correctable one.
- A flag clear landing in the same cycle as a new event. A design that gets the priority backwards would lose the event.
- Writes aimed at the master-id and other capture offsets. A design that gets this wrong would change a value that is meant to be read-only.
- Events of a disabled type. A design with a leaky gate would overwrite the last record.

Random event and register traffic then checks every read against a model, using the one-cycle read latency.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_DW = 32;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFF_CFG  = 4'd0;
  localparam logic [REG_AW-1:0] OFF_STAT = 4'd1;
  localparam logic [REG_AW-1:0] OFF_ADDR = 4'd2;
  localparam logic [REG_AW-1:0] OFF_SYN  = 4'd3;
  localparam logic [REG_AW-1:0] OFF_MID  = 4'd4;
  localparam logic [REG_AW-1:0] OFF_ATTR = 4'd5;
  localparam logic [REG_AW-1:0] OFF_DATA = 4'd6;

  typedef struct packed {
    logic nce;
    logic sbc;
  } ev_t;
endpackage

// File: rtl/ecc_cap_classify.sv
module ecc_cap_classify
  import ecc_cap_pkg::*;
#(
  parameter int SYN_W = 8,
  parameter logic [SYN_W-1:0] SBC_SYN_MAX = 8'h4d
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sbc_i,
  input  logic             nce_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             en_sbc_i,
  input  logic             en_nce_i,
  output ev_t              set_o,
  output logic             cap_o
);
  logic syn_multi, is_nce, is_sbc;

  // syndrome beyond the single-bit table means multi-bit
  assign syn_multi = syn_i > SBC_SYN_MAX;
  assign is_nce    = nce_i | (sbc_i & syn_multi);
  assign is_sbc    = sbc_i & ~is_nce;

  assign set_o.sbc = is_sbc & en_sbc_i;
  assign set_o.nce = is_nce & en_nce_i;
  assign cap_o     = set_o.sbc | set_o.nce;

  assert_both_pulses_nce_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbc_i && nce_i) |-> !set_o.sbc);
  assert_bad_syn_not_sbc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbc_i && syn_i > SBC_SYN_MAX) |-> !set_o.sbc);
  assert_disabled_no_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_sbc_i && !en_nce_i) |-> !cap_o);
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int MID_W  = 4,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic [MID_W-1:0]  mid_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      syn_o  <= '0;
      mid_o  <= '0;
      attr_o <= '0;
      data_o <= '0;
    end else if (cap_i) begin
      addr_o <= addr_i;
      syn_o  <= syn_i;
      mid_o  <= mid_i;
      attr_o <= attr_i;
      data_o <= data_i;
    end
  end

  assert_load_together_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (addr_o == $past(addr_i)) && (syn_o == $past(syn_i)) &&
              (mid_o == $past(mid_i)) && (attr_o == $past(attr_i)) &&
              (data_o == $past(data_i)));
  assert_hold_no_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(addr_o) && $stable(syn_o) && $stable(mid_o) &&
               $stable(attr_o) && $stable(data_o));
endmodule

// File: rtl/ecc_cap_regs.sv
module ecc_cap_regs
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int MID_W  = 4,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  ev_t               set_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [SYN_W-1:0]  cap_syn_i,
  input  logic [MID_W-1:0]  cap_mid_i,
  input  logic [ATTR_W-1:0] cap_attr_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              en_sbc_o,
  output logic              en_nce_o,
  output logic [REG_DW-1:0] rdata_o
);
  localparam int DATA_WORDS = (DATA_W + REG_DW - 1) / REG_DW;
  localparam int LAST_OFF   = int'(OFF_DATA) + DATA_WORDS - 1;

  logic [1:0] cfg_q, stat_q, stat_clr;
  logic [DATA_WORDS*REG_DW-1:0] data_pad;
  logic [REG_DW-1:0] data_word [DATA_WORDS];
  logic [REG_DW-1:0] rd_d;

  always_comb begin
    data_pad = '0;
    data_pad[DATA_W-1:0] = cap_data_i;
  end

  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_dword
    assign data_word[w] = data_pad[w*REG_DW +: REG_DW];
  end

  assign stat_clr = (wr_i && addr_i == OFF_STAT) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_i && addr_i == OFF_CFG) cfg_q <= wdata_i[1:0];
      // set dominates clear
      stat_q <= (stat_q & ~stat_clr) | {set_i.nce, set_i.sbc};
    end
  end

  assign en_sbc_o = cfg_q[0];
  assign en_nce_o = cfg_q[1];

  always_comb begin
    rd_d = '0;
    unique case (addr_i)
      OFF_CFG:  rd_d[1:0] = cfg_q;
      OFF_STAT: rd_d[1:0] = stat_q;
      OFF_ADDR: rd_d[ADDR_W-1:0] = cap_addr_i;
      OFF_SYN:  rd_d[SYN_W-1:0] = cap_syn_i;
      OFF_MID:  rd_d[MID_W-1:0] = cap_mid_i;
      OFF_ATTR: rd_d[ATTR_W-1:0] = cap_attr_i;
      default: begin
        for (int w = 0; w < DATA_WORDS; w++)
          if (int'(addr_i) == int'(OFF_DATA) + w) rd_d = data_word[w];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i.sbc |=> stat_q[0]);
  assert_set_wins_nce_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i.nce |=> stat_q[1]);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_STAT && wdata_i[0] && !set_i.sbc) |=> !stat_q[0]);
  assert_one_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_i.sbc, set_i.nce}));
  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && int'($past(addr_i)) > LAST_OFF) |-> rdata_o == '0);
endmodule

// File: rtl/ecc_event_capture.sv
module ecc_event_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int MID_W  = 4,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbc_pulse_i,
  input  logic              nce_pulse_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic [MID_W-1:0]  err_mid_i,
  input  logic [ATTR_W-1:0] err_attr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  ev_t               set;
  logic              cap, en_sbc, en_nce;
  logic [ADDR_W-1:0] q_addr;
  logic [SYN_W-1:0]  q_syn;
  logic [MID_W-1:0]  q_mid;
  logic [ATTR_W-1:0] q_attr;
  logic [DATA_W-1:0] q_data;

  ecc_cap_classify #(.SYN_W(SYN_W)) u_classify (
    .clk_i, .rst_ni,
    .sbc_i(sbc_pulse_i), .nce_i(nce_pulse_i), .syn_i(err_syn_i),
    .en_sbc_i(en_sbc), .en_nce_i(en_nce),
    .set_o(set), .cap_o(cap)
  );

  ecc_cap_store #(
    .ADDR_W(ADDR_W), .SYN_W(SYN_W), .MID_W(MID_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i, .rst_ni, .cap_i(cap),
    .addr_i(err_addr_i), .syn_i(err_syn_i), .mid_i(err_mid_i),
    .attr_i(err_attr_i), .data_i(err_data_i),
    .addr_o(q_addr), .syn_o(q_syn), .mid_o(q_mid), .attr_o(q_attr), .data_o(q_data)
  );

  ecc_cap_regs #(
    .ADDR_W(ADDR_W), .SYN_W(SYN_W), .MID_W(MID_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .set_i(set),
    .cap_addr_i(q_addr), .cap_syn_i(q_syn), .cap_mid_i(q_mid),
    .cap_attr_i(q_attr), .cap_data_i(q_data),
    .en_sbc_o(en_sbc), .en_nce_o(en_nce),
    .rdata_o(reg_rdata_o)
  );

  assert_mid_read_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap && reg_wr_i) |=> $stable(q_mid) && $stable(q_addr));
endmodule

// File: tb/ecc_event_capture_tb.sv
module ecc_event_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbc, nce;
  logic [31:0] e_addr;
  logic [7:0]  e_syn, e_attr;
  logic [3:0]  e_mid;
  logic [63:0] e_data;
  logic        wr;
  logic [3:0]  raddr;
  logic [31:0] wdata, rdata;

  always #2.5ns clk = ~clk;

  ecc_event_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sbc_pulse_i(sbc), .nce_pulse_i(nce),
    .err_addr_i(e_addr), .err_syn_i(e_syn), .err_mid_i(e_mid),
    .err_attr_i(e_attr), .err_data_i(e_data),
    .reg_wr_i(wr), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [1:0]  m_cfg, m_st;
  logic [31:0] m_addr;
  logic [7:0]  m_syn, m_attr;
  logic [3:0]  m_mid;
  logic [63:0] m_data;

  bit          pend = 0;
  logic [31:0] pend_exp;
  string       pend_tag;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, m_cfg};
      4'd1: return {30'd0, m_st};
      4'd2: return m_addr;
      4'd3: return {24'd0, m_syn};
      4'd4: return {28'd0, m_mid};
      4'd5: return {24'd0, m_attr};
      4'd6: return m_data[31:0];
      4'd7: return m_data[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare();
    n_cmp++;
    if (rdata !== pend_exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h", pend_tag, rdata, pend_exp);
    end
  endtask

  task automatic step(input logic s, input logic n, input logic [7:0] syn,
                      input logic w, input logic [3:0] a, input logic [31:0] wd,
                      input string tag);
    logic is_n, is_s, cs, cn;
    @(negedge clk);
    if (pend) compare();
    sbc = s; nce = n; e_syn = syn;
    e_addr = $urandom; e_mid = 4'($urandom); e_attr = 8'($urandom);
    e_data = {$urandom, $urandom};
    wr = w; raddr = a; wdata = wd;
    pend = 1; pend_exp = m_read(a); pend_tag = tag;
    is_n = n | (s & (syn > 8'h4d));
    is_s = s & ~is_n;
    cs = is_s & m_cfg[0];
    cn = is_n & m_cfg[1];
    if (w && a == 4'd1) m_st = m_st & ~wd[1:0];
    if (w && a == 4'd0) m_cfg = wd[1:0];
    if (cs) m_st[0] = 1'b1;
    if (cn) m_st[1] = 1'b1;
    if (cs | cn) begin
      m_addr = e_addr; m_syn = syn; m_mid = e_mid; m_attr = e_attr; m_data = e_data;
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b0, 1'b0, 8'h00, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    sbc = 0; nce = 0; e_addr = 0; e_syn = 0; e_mid = 0; e_attr = 0; e_data = 0;
    wr = 0; raddr = 0; wdata = 0;
    m_cfg = 0; m_st = 0; m_addr = 0; m_syn = 0; m_mid = 0; m_attr = 0; m_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 8; a++) rd(4'(a), "R1 reset");
    // disabled types
    step(1'b1, 1'b0, 8'h4c, 1'b0, 4'd1, 0, "R4 status");
    step(1'b0, 1'b1, 8'h70, 1'b0, 4'd2, 0, "R4 addr");
    rd(4'd1, "R4 status");
    rd(4'd4, "R4 mid");
    // enables
    step(1'b0, 1'b0, 0, 1'b1, 4'd0, 32'hffff_fffd, "R12 cfg pre");
    rd(4'd0, "R12 cfg");
    step(1'b0, 1'b0, 0, 1'b1, 4'd0, 32'h3, "R12 cfg");
    // correctable capture
    step(1'b1, 1'b0, 8'h4c, 1'b0, 4'd1, 0, "R2");
    rd(4'd1, "R2 flag");
    rd(4'd3, "R2 syn");
    rd(4'd4, "R2 mid");
    rd(4'd2, "R2 addr");
    rd(4'd5, "R2 attr");
    rd(4'd6, "R2 data lo");
    rd(4'd7, "R2 data hi");
    // clear with zero, then one
    step(1'b0, 1'b0, 0, 1'b1, 4'd1, 32'h0, "R8");
    rd(4'd1, "R8 write zero");
    step(1'b0, 1'b0, 0, 1'b1, 4'd1, 32'h1, "R8");
    rd(4'd1, "R8 clear");
    // syndrome boundary
    step(1'b1, 1'b0, 8'h4d, 1'b0, 4'd3, 0, "R5");
    rd(4'd1, "R5 0x4d correctable");
    step(1'b0, 1'b0, 0, 1'b1, 4'd1, 32'h3, "R5");
    step(1'b1, 1'b0, 8'h4e, 1'b0, 4'd3, 0, "R5");
    rd(4'd1, "R5 0x4e non-correctable");
    rd(4'd3, "R5 syn");
    // both pulses
    step(1'b0, 1'b0, 0, 1'b1, 4'd1, 32'h3, "R6");
    step(1'b1, 1'b1, 8'h40, 1'b0, 4'd1, 0, "R6");
    rd(4'd1, "R6 both");
    rd(4'd3, "R3 syn");
    // non-correctable only, flag set via nce
    step(1'b0, 1'b0, 0, 1'b1, 4'd1, 32'h3, "R3");
    step(1'b0, 1'b1, 8'h12, 1'b0, 4'd0, 0, "R3");
    rd(4'd1, "R3 flag");
    // clear and set same cycle
    step(1'b1, 1'b0, 8'h24, 1'b1, 4'd1, 32'h3, "R9");
    rd(4'd1, "R9 set wins");
    // read-only capture
    step(1'b0, 1'b0, 0, 1'b1, 4'd4, 32'hf, "R10");
    rd(4'd4, "R10 mid");
    step(1'b0, 1'b0, 0, 1'b1, 4'd2, 32'hdead_beef, "R10");
    rd(4'd2, "R10 addr");
    // unmapped
    for (int a = 8; a < 16; a++) rd(4'(a), "R11 unmapped");
    // overwrite
    step(1'b1, 1'b0, 8'h30, 1'b0, 4'd0, 0, "R7");
    step(1'b1, 1'b0, 8'h32, 1'b0, 4'd0, 0, "R7");
    rd(4'd3, "R7 newest syn");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic s, n, w;
      logic [7:0] sy;
      logic [3:0] a;
      logic [31:0] wd;
      s  = ($urandom % 4) == 0;
      n  = ($urandom % 6) == 0;
      sy = ($urandom % 2) ? 8'($urandom % 8'h50) : 8'($urandom);
      w  = ($urandom % 5) == 0;
      a  = 4'($urandom);
      wd = $urandom;
      step(s, n, sy, w, a, wd, "R7 random");
    end
    @(negedge clk);
    if (pend) compare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule